// File: doc/BRIEF.md
# Dual-Rail AMI Line Encoder with Bipolar Violation Insertion

This block turns the single-rail transmit bit stream of a T1/E1 transmitter into alternate-mark-inversion code on two rails, a positive rail and a negative rail. A one, called a mark, is normally sent on the rail opposite to the one used by the previous mark. A zero, called a space, leaves both rails low. Transmit data and a violation-request pin are sampled on the falling edge of the transmit clock. The encoded rails are registered and change on the rising edge that follows.

A low-to-high step on the request pin arms one bipolar violation. The next mark that goes out on the line then repeats the polarity of the previous mark instead of alternating. Insertion works only when the block is set for single-rail input with AMI coding. A transmit-all-ones setting forces every bit to a mark. When all-ones is combined with a loopback setting, violation requests are either dropped, or, for digital loopback, returned to the system side on a separate output.

Top module: `ami_violation_encoder`

## Requirements
- R1: While `rst` is high, and on the first rising edge after it falls, both rails and `bpv_loop_out` are low. The stored last-mark polarity resets to negative, so the first mark after reset is sent on `line_pos`.
- R2: A normal mark goes on the rail opposite to the previous mark. A space drives both rails low. `line_pos` and `line_neg` are never high together.
- R3: `tx_data` and `bpv_req` are captured on the falling edge of `clk`. The encoded bit appears on the rails at the next rising edge.
- R4: A violation is armed only when `bpv_req` is sampled high after being sampled low. Holding the pin high arms nothing more.
- R5: An armed violation applies to the first mark sampled on or after the falling edge that saw the low-to-high step. Spaces before that mark go out as spaces and keep the violation pending.
- R6: A violation mark goes on the same rail as the previous mark. The stored polarity is left unchanged, so the next normal mark goes on the opposite rail.
- R7: At most one violation is pending. A further low-to-high step while one is pending does not queue a second violation.
- R8: Insertion is enabled only when `cfg_single_rail` = 1 and `cfg_ami_en` = 1. Otherwise a request step is dropped, and any pending violation is cleared.
- R9: With `cfg_taos` = 1, every bit is sent as a mark whatever `tx_data` is. With `cfg_loop` = 0 (none), or with an unused code 5 to 7, insertion still works.
- R10: With `cfg_taos` = 1 and `cfg_loop` = 1 (analog), 2 (remote) or 4 (inband), requests are ignored and pending violations are cleared.
- R11: With `cfg_taos` = 1 and `cfg_loop` = 3 (digital), the rails carry all ones with no violation. `bpv_loop_out` then shows the `bpv_req` level sampled on the preceding falling edge, one rising edge later. In every other setting `bpv_loop_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock; inputs are sampled on its falling edge, outputs change on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_single_rail | input | 1 | Single-rail input selected |
| cfg_ami_en | input | 1 | AMI line code selected |
| cfg_taos | input | 1 | Transmit all ones |
| cfg_loop | input | 3 | Loopback: 0 none, 1 analog, 2 remote, 3 digital, 4 inband, 5 to 7 none |
| tx_data | input | 1 | Single-rail transmit bit |
| bpv_req | input | 1 | Violation request; a low-to-high step arms one violation |
| line_pos | output | 1 | Positive rail |
| line_neg | output | 1 | Negative rail |
| bpv_loop_out | output | 1 | Request level returned to the system side during all-ones with digital loopback |

## Verification
The hardest case to reach from the ports is a pending violation meeting a change of state before any mark arrives. This can be a second request step that must not stack, or a configuration change that must clear the pending violation rather than leave it for later. The directed part of the bench arms a violation during a run of spaces. It then either pulses the request again or switches off single-rail or AMI coding, and only then sends marks. The random part changes the configuration every few cycles while spaces dominate, so pending violations often span configuration changes.

// File: rtl/ami_enc_pkg.sv
package ami_enc_pkg;
  localparam int LOOP_W = 3;

  typedef enum logic [LOOP_W-1:0] {
    LB_NONE    = 3'd0,
    LB_ANALOG  = 3'd1,
    LB_REMOTE  = 3'd2,
    LB_DIGITAL = 3'd3,
    LB_INBAND  = 3'd4
  } loop_mode_e;

  function automatic logic loop_blocks_line(input logic [LOOP_W-1:0] code);
    return (code == LB_ANALOG) || (code == LB_REMOTE) ||
           (code == LB_DIGITAL) || (code == LB_INBAND);
  endfunction
endpackage

// File: rtl/ami_sampler.sv
// Falling-edge capture of data and request, with step detection.
module ami_sampler (
  input  logic clk,
  input  logic rst,
  input  logic tx_data,
  input  logic bpv_req,
  output logic data_s,
  output logic req_s,
  output logic req_step
);
  logic req_prev;

  always_ff @(negedge clk) begin
    if (rst) begin
      data_s   <= 1'b0;
      req_s    <= 1'b0;
      req_prev <= 1'b0;
    end else begin
      data_s   <= tx_data;
      req_s    <= bpv_req;
      req_prev <= req_s;
    end
  end

  assign req_step = req_s & ~req_prev;
endmodule

// File: rtl/ami_bpv_ctrl.sv
// Decides whether a violation is armed, pending or applied, and drives the
// system-side loop output.
module ami_bpv_ctrl
  import ami_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_single_rail,
  input  logic              cfg_ami_en,
  input  logic              cfg_taos,
  input  logic [LOOP_W-1:0] cfg_loop,
  input  logic              req_s,
  input  logic              req_step,
  input  logic              mark,
  output logic              viol,
  output logic              loop_out
);
  logic pending;
  logic line_ok;
  logic want;
  logic loop_back;

  assign loop_back = cfg_taos && (cfg_loop == LB_DIGITAL);
  assign line_ok   = cfg_single_rail && cfg_ami_en &&
                     !(cfg_taos && loop_blocks_line(cfg_loop));
  assign want      = line_ok && (pending || req_step);
  assign viol      = want && mark;

  always_ff @(posedge clk) begin
    if (rst) begin
      pending  <= 1'b0;
      loop_out <= 1'b0;
    end else begin
      pending  <= want && !mark;
      loop_out <= loop_back && req_s;
    end
  end
endmodule

// File: rtl/ami_rail_encoder.sv
// Alternating-polarity rail generation with same-polarity violation marks.
module ami_rail_encoder (
  input  logic clk,
  input  logic rst,
  input  logic mark,
  input  logic viol,
  output logic line_pos,
  output logic line_neg
);
  logic last_pos;
  logic send_pos;

  assign send_pos = viol ? last_pos : !last_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_pos <= 1'b0;
      line_pos <= 1'b0;
      line_neg <= 1'b0;
    end else begin
      line_pos <= mark && send_pos;
      line_neg <= mark && !send_pos;
      if (mark) last_pos <= send_pos;
    end
  end
endmodule

// File: rtl/ami_violation_encoder.sv
module ami_violation_encoder
  import ami_enc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_single_rail,
  input  logic              cfg_ami_en,
  input  logic              cfg_taos,
  input  logic [LOOP_W-1:0] cfg_loop,
  input  logic              tx_data,
  input  logic              bpv_req,
  output logic              line_pos,
  output logic              line_neg,
  output logic              bpv_loop_out
);
  logic data_s;
  logic req_s;
  logic req_step;
  logic mark;
  logic viol;

  ami_sampler u_samp (
    .clk      (clk),
    .rst      (rst),
    .tx_data  (tx_data),
    .bpv_req  (bpv_req),
    .data_s   (data_s),
    .req_s    (req_s),
    .req_step (req_step)
  );

  assign mark = cfg_taos | data_s;

  ami_bpv_ctrl u_ctrl (
    .clk             (clk),
    .rst             (rst),
    .cfg_single_rail (cfg_single_rail),
    .cfg_ami_en      (cfg_ami_en),
    .cfg_taos        (cfg_taos),
    .cfg_loop        (cfg_loop),
    .req_s           (req_s),
    .req_step        (req_step),
    .mark            (mark),
    .viol            (viol),
    .loop_out        (bpv_loop_out)
  );

  ami_rail_encoder u_enc (
    .clk      (clk),
    .rst      (rst),
    .mark     (mark),
    .viol     (viol),
    .line_pos (line_pos),
    .line_neg (line_neg)
  );
endmodule

// File: rtl/ami_enc_checker.sv
module ami_enc_checker
  import ami_enc_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cfg_single_rail,
  input logic              cfg_ami_en,
  input logic              cfg_taos,
  input logic [LOOP_W-1:0] cfg_loop,
  input logic              line_pos,
  input logic              line_neg,
  input logic              bpv_loop_out
);
  logic ck_last_pos;
  logic bpv_ok;

  assign bpv_ok = cfg_single_rail && cfg_ami_en &&
                  !(cfg_taos && (cfg_loop >= 3'd1) && (cfg_loop <= 3'd4));

  always_ff @(posedge clk) begin
    if (rst) ck_last_pos <= 1'b0;
    else if (line_pos) ck_last_pos <= 1'b1;
    else if (line_neg) ck_last_pos <= 1'b0;
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!line_pos && !line_neg && !bpv_loop_out)); // R1
  AST_RAILS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(line_pos && line_neg)); // R2
  AST_REPEAT_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    ((line_pos && ck_last_pos) || (line_neg && !ck_last_pos)) |-> $past(bpv_ok)); // R8
  AST_TAOS_ALL_MARKS: assert property (@(posedge clk) disable iff (rst)
    $past(cfg_taos) |-> (line_pos || line_neg)); // R9
  AST_LOOP_ONLY_DIGITAL: assert property (@(posedge clk) disable iff (rst)
    bpv_loop_out |-> ($past(cfg_taos) && ($past(cfg_loop) == 3'd3))); // R11
endmodule

bind ami_violation_encoder ami_enc_checker chk_i (
  .clk             (clk),
  .rst             (rst),
  .cfg_single_rail (cfg_single_rail),
  .cfg_ami_en      (cfg_ami_en),
  .cfg_taos        (cfg_taos),
  .cfg_loop        (cfg_loop),
  .line_pos        (line_pos),
  .line_neg        (line_neg),
  .bpv_loop_out    (bpv_loop_out)
);

// File: tb/ami_violation_encoder_tb_top.sv
module ami_violation_encoder_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_single_rail = 1'b1;
  logic       cfg_ami_en = 1'b1;
  logic       cfg_taos = 1'b0;
  logic [2:0] cfg_loop = 3'd0;
  logic       tx_data = 1'b0;
  logic       bpv_req = 1'b0;
  logic       line_pos, line_neg, bpv_loop_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  ami_violation_encoder dut_i (
    .clk(clk), .rst(rst), .cfg_single_rail(cfg_single_rail),
    .cfg_ami_en(cfg_ami_en), .cfg_taos(cfg_taos), .cfg_loop(cfg_loop),
    .tx_data(tx_data), .bpv_req(bpv_req), .line_pos(line_pos),
    .line_neg(line_neg), .bpv_loop_out(bpv_loop_out)
  );

  // Reference state built from the requirements
  bit m_last_pos, m_pend, m_prev_req;
  bit e_pos, e_neg, e_loop;
  string e_tag;

  task automatic check(input string tag, input bit act, input bit exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0b expected=%0b", tag, what, act, exp);
    end
  endtask

  // Predict the outputs for the bit driven now (appear after next rising edge).
  function automatic void predict(input bit d, input bit r);
    bit rise, ok, mk, arm, want, viol, snd;
    rise = r && !m_prev_req;
    m_prev_req = r;
    ok = cfg_single_rail && cfg_ami_en &&
         !(cfg_taos && cfg_loop >= 3'd1 && cfg_loop <= 3'd4);
    mk = cfg_taos || d;
    arm = ok && rise;
    want = ok && (m_pend || arm);
    viol = want && mk;
    if      (viol)                        e_tag = "R6";
    else if (cfg_taos && cfg_loop == 3'd3) e_tag = "R11";
    else if (cfg_taos && !ok)              e_tag = "R10";
    else if (cfg_taos)                     e_tag = "R9";
    else if (rise && !ok)                  e_tag = "R8";
    else if (rise && m_pend)               e_tag = "R7";
    else if (m_pend && !mk)                e_tag = "R5";
    else if (rise)                         e_tag = "R4";
    else if (mk)                           e_tag = "R2";
    else                                   e_tag = "R3";
    snd = viol ? m_last_pos : !m_last_pos;
    e_pos = mk && snd;
    e_neg = mk && !snd;
    if (mk) m_last_pos = snd;
    m_pend = want && !mk;
    e_loop = cfg_taos && cfg_loop == 3'd3 && r;
  endfunction

  task automatic cyc(input bit d, input bit r);
    tx_data = d;
    bpv_req = r;
    predict(d, r);
    @(posedge clk); #1;
    check(e_tag, line_pos, e_pos, "line_pos");
    check(e_tag, line_neg, e_neg, "line_neg");
    check(e_tag, bpv_loop_out, e_loop, "bpv_loop_out");
  endtask

  task automatic set_cfg(input bit sr, input bit ami, input bit taos, input bit [2:0] lp);
    cfg_single_rail = sr; cfg_ami_en = ami; cfg_taos = taos; cfg_loop = lp;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED));
    // R1: reset holds outputs low
    for (int i = 0; i < 4; i++) begin
      @(posedge clk); #1;
      check("R1", line_pos, 1'b0, "line_pos in reset");
      check("R1", line_neg, 1'b0, "line_neg in reset");
      check("R1", bpv_loop_out, 1'b0, "loop in reset");
    end
    rst = 1'b0;
    m_last_pos = 0; m_pend = 0; m_prev_req = 0;
    // R1 first mark positive, R2 alternation and spaces
    cyc(1, 0);
    check("R1", line_pos, 1'b1, "first mark on positive rail");
    cyc(1, 0); cyc(0, 0); cyc(1, 0); cyc(1, 0);
    // R4, R5: step during spaces, violation on first later mark
    cyc(0, 1); cyc(0, 1); cyc(0, 1); cyc(1, 1);
    // R4: level held high arms nothing more; R6 next normal mark alternates
    cyc(1, 1); cyc(1, 1); cyc(0, 0);
    // R7: second step while pending does not queue
    cyc(0, 1); cyc(0, 0); cyc(0, 1); cyc(1, 0); cyc(1, 0); cyc(1, 0);
    // R8: disabled coding drops the step and clears pending
    set_cfg(0, 1, 0, 3'd0); cyc(1, 1); cyc(1, 0);
    set_cfg(1, 1, 0, 3'd0); cyc(0, 1); set_cfg(1, 0, 0, 3'd0); cyc(0, 0);
    set_cfg(1, 1, 0, 3'd0); cyc(1, 0); cyc(1, 0);
    // R9: all ones with insertion still live
    set_cfg(1, 1, 1, 3'd0); cyc(0, 0); cyc(0, 1); cyc(0, 0); cyc(0, 0);
    set_cfg(1, 1, 1, 3'd6); cyc(0, 1); cyc(0, 0);
    // R10: analog, remote, inband loopbacks drop requests
    for (int k = 0; k < 3; k++) begin
      set_cfg(1, 1, 1, (k == 0) ? 3'd1 : (k == 1) ? 3'd2 : 3'd4);
      cyc(0, 0); cyc(1, 1); cyc(0, 0); cyc(1, 0);
    end
    // R11: digital loopback returns the request level
    set_cfg(1, 1, 1, 3'd3); cyc(0, 0); cyc(0, 1); cyc(1, 1); cyc(0, 0); cyc(1, 1);
    set_cfg(1, 1, 0, 3'd3); cyc(1, 1); cyc(0, 0);
    // Random phase
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 16) == 0) begin
        bit [3:0] pick;
        pick = 4'($urandom);
        set_cfg(pick != 0, pick != 1, pick >= 11, 3'($urandom));
      end
      cyc(($urandom % 3) == 0, ($urandom % 4) == 0);
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule